// File: doc/BRIEF.md
# Two-Channel Window Filter Bank

The block checks the newest converter samples of two analog channels against a bank of eight programmable window filters per channel. Each filter carries a lower bound, an upper bound, a condition selecting an inside-window or an outside-window test, and an enable bit. A filter slot counts as matched only when the filter at that slot matches on both channels. The eight per-slot results form a match vector that is registered for the sampling sequencer.

Each channel presents a 10-bit sample with its own valid strobe. The block keeps the latest sample of every channel. The strobe of the last channel starts an evaluation, which uses the sample arriving with that strobe together with the held samples of the other channel. The match vector is then held until the next evaluation.

Top module: `adc_win_filter_bank`

## Requirements
- R1: After reset, match_o is 0, every held sample is 0 and every filter configuration input is treated as given by its port.
- R2: Each 32-bit filter word is decoded as lower bound in bits [11:2], condition in bit [12], upper bound in bits [27:18] and enable in bit [31]; the remaining bits have no effect. Word f of channel c sits at cfg_i bits [(c*8+f)*32 +: 32].
- R3: With condition 0, a filter matches when lower ≤ sample ≤ upper, both bounds inclusive.
- R4: With condition 1, a filter matches when sample > upper or sample < lower.
- R5: A filter whose enable bit is 0 never matches.
- R6: match_o bit i is 1 only when filter i matches on channel 0 and on channel 1; if filter i is enabled on one channel and disabled on the other, bit i is 0.
- R7: match_o changes only on the clock edge at which the channel 1 strobe (smp_vld_i[1]) is high, taking the result of that evaluation one cycle after the strobe; at every other edge it holds its value.
- R8: When the lower bound exceeds the upper bound, an inside-window filter never matches and an outside-window filter always matches (if enabled).
- R9: A channel 0 strobe alone only stores the channel 0 sample; the next channel 1 strobe evaluates with that stored value. When both strobes are high in the same cycle, both incoming samples are used.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| smp_i | input | 20 | Channel samples, channel c at bits [c*10 +: 10] |
| smp_vld_i | input | 2 | Per-channel sample valid strobes; bit 1 triggers evaluation |
| cfg_i | input | 512 | Filter words, 8 per channel, 32 bits each |
| match_o | output | 8 | Registered per-slot match vector |

## Verification
The assertions take for granted that the filter words are stable in the cycle an evaluation is triggered, and that the strobes are single-cycle pulses driven clear of the clock edge. The stimulus changes configuration only while no strobe is high and drives every strobe and sample at the falling edge, one pulse at a time. Expected vectors come from a bench model that rewrites the window test as a negated out-of-range check, so the in-window, out-of-window, swapped-bound and one-sided-enable cases are judged independently of the RTL expressions.

// File: rtl/adc_wflt_pkg.sv
package adc_wflt_pkg;

  localparam int unsigned SMP_W    = 10;
  localparam int unsigned CFG_W    = 32;
  localparam int unsigned LO_LSB   = 2;
  localparam int unsigned COND_BIT = 12;
  localparam int unsigned HI_LSB   = 18;
  localparam int unsigned EN_BIT   = 31;

  typedef logic [SMP_W-1:0] smp_t;

  typedef struct packed {
    logic en;
    logic outside;
    smp_t hi;
    smp_t lo;
  } flt_cfg_t;

  function automatic flt_cfg_t unpack_cfg(input logic [CFG_W-1:0] w);
    flt_cfg_t c;
    c.en      = w[EN_BIT];
    c.outside = w[COND_BIT];
    c.hi      = w[HI_LSB +: SMP_W];
    c.lo      = w[LO_LSB +: SMP_W];
    return c;
  endfunction

  function automatic logic in_window(input smp_t lo, input smp_t hi, input smp_t s);
    return (s >= lo) && (s <= hi);
  endfunction

  function automatic logic out_window(input smp_t lo, input smp_t hi, input smp_t s);
    return (s > hi) || (s < lo);
  endfunction

  function automatic logic flt_hit(input flt_cfg_t c, input smp_t s);
    logic cond_ok;
    cond_ok = c.outside ? out_window(c.lo, c.hi, s) : in_window(c.lo, c.hi, s);
    return c.en && cond_ok;
  endfunction

endpackage

// File: rtl/adc_flt_cell.sv
module adc_flt_cell
  import adc_wflt_pkg::*;
(
  input  logic [CFG_W-1:0] cfg_word_i,
  input  smp_t             smp_i,
  output logic             hit_o
);

  flt_cfg_t cfg;
  logic     unused_rsvd;

  assign cfg         = unpack_cfg(cfg_word_i);
  assign unused_rsvd = ^{cfg_word_i[LO_LSB-1:0],
                         cfg_word_i[HI_LSB-1:COND_BIT+1],
                         cfg_word_i[EN_BIT-1:HI_LSB+SMP_W]};
  assign hit_o       = flt_hit(cfg, smp_i);

endmodule

// File: rtl/adc_flt_chan.sv
module adc_flt_chan
  import adc_wflt_pkg::*;
#(
  parameter int unsigned NUM_FLT = 8
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  smp_t                     smp_i,
  input  logic                     vld_i,
  input  logic [NUM_FLT*CFG_W-1:0] cfg_i,
  output logic [NUM_FLT-1:0]       hit_o
);

  smp_t held_q;
  smp_t eff_smp;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      held_q <= '0;
    end else if (vld_i) begin
      held_q <= smp_i;
    end
  end

  // a sample arriving now takes part in this cycle's evaluation
  assign eff_smp = vld_i ? smp_i : held_q;

  for (genvar f = 0; f < NUM_FLT; f++) begin : g_cell
    adc_flt_cell u_cell (
      .cfg_word_i (cfg_i[f*CFG_W +: CFG_W]),
      .smp_i      (eff_smp),
      .hit_o      (hit_o[f])
    );
  end

endmodule

// File: rtl/adc_win_filter_bank.sv
module adc_win_filter_bank
  import adc_wflt_pkg::*;
#(
  parameter int unsigned NUM_CH  = 2,
  parameter int unsigned NUM_FLT = 8
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic [NUM_CH*SMP_W-1:0]         smp_i,
  input  logic [NUM_CH-1:0]               smp_vld_i,
  input  logic [NUM_CH*NUM_FLT*CFG_W-1:0] cfg_i,
  output logic [NUM_FLT-1:0]              match_o
);

  localparam int unsigned CH_CFG_W = NUM_FLT * CFG_W;

  logic [NUM_CH*NUM_FLT-1:0] hit_all;
  logic [NUM_FLT-1:0]        hit_and;
  logic [NUM_FLT-1:0]        match_q;
  logic                      eval_go;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
    adc_flt_chan #(.NUM_FLT(NUM_FLT)) u_chan (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .smp_i  (smp_i[c*SMP_W +: SMP_W]),
      .vld_i  (smp_vld_i[c]),
      .cfg_i  (cfg_i[c*CH_CFG_W +: CH_CFG_W]),
      .hit_o  (hit_all[c*NUM_FLT +: NUM_FLT])
    );
  end

  // the last channel's strobe closes a sampling round
  assign eval_go = smp_vld_i[NUM_CH-1];

  always_comb begin
    hit_and = '1;
    for (int c = 0; c < NUM_CH; c++) begin
      hit_and = hit_and & hit_all[c*NUM_FLT +: NUM_FLT];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      match_q <= '0;
    end else if (eval_go) begin
      match_q <= hit_and;
    end
  end

  assign match_o = match_q;

endmodule

// File: rtl/adc_win_filter_bank_chk.sv
module adc_win_filter_bank_chk
  import adc_wflt_pkg::*;
#(
  parameter int unsigned NUM_CH  = 2,
  parameter int unsigned NUM_FLT = 8
) (
  input logic                            clk_i,
  input logic                            rst_ni,
  input logic                            eval_go,
  input logic [NUM_CH*NUM_FLT-1:0]       hit_all,
  input logic [NUM_CH*NUM_FLT*CFG_W-1:0] cfg_i,
  input logic [NUM_FLT-1:0]              match_o
);

  logic [NUM_CH*NUM_FLT-1:0] en_all;
  logic [NUM_FLT-1:0]        all_hit;
  logic [NUM_FLT-1:0]        all_en;
  logic                      unused_cfg;

  always_comb begin
    unused_cfg = 1'b0;
    for (int k = 0; k < NUM_CH*NUM_FLT; k++) begin
      en_all[k]  = cfg_i[k*CFG_W + EN_BIT];
      unused_cfg = unused_cfg ^ (^cfg_i[k*CFG_W +: EN_BIT]);
    end
    all_hit = '1;
    all_en  = '1;
    for (int c = 0; c < NUM_CH; c++) begin
      all_hit = all_hit & hit_all[c*NUM_FLT +: NUM_FLT];
      all_en  = all_en  & en_all[c*NUM_FLT +: NUM_FLT];
    end
  end

  // R7: no strobe on the last channel, no change on the output
  p_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !eval_go |=> $stable(match_o));

  // R6: an evaluation stores the conjunction of the channel hits
  p_and_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eval_go |=> (match_o == $past(all_hit)));

  // R5: a slot cannot match unless it is enabled on every channel
  p_match_en_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eval_go |=> ((match_o & ~$past(all_en)) == '0));

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch_chk
    // R5: a disabled filter never reports a hit on its channel
    p_dis_no_hit_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ((hit_all[c*NUM_FLT +: NUM_FLT] & ~en_all[c*NUM_FLT +: NUM_FLT]) == '0));
  end

endmodule

bind adc_win_filter_bank adc_win_filter_bank_chk #(
  .NUM_CH  (NUM_CH),
  .NUM_FLT (NUM_FLT)
) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .eval_go (eval_go),
  .hit_all (hit_all),
  .cfg_i   (cfg_i),
  .match_o (match_o)
);

// File: tb/test_adc_win_filter_bank.sv
module test_adc_win_filter_bank;

  localparam int NCH = 2;
  localparam int NF  = 8;
  localparam int NV  = 7;

  // stimulus vectors: {ch0 sample, ch1 sample}
  localparam logic [19:0] VEC [NV] = '{
    {10'd150, 10'd150}, {10'd100, 10'd200}, {10'd99, 10'd201},
    {10'd512, 10'd512}, {10'd0, 10'd1023}, {10'd150, 10'd50},
    {10'd512, 10'd150}
  };

  logic                   clk_i = 1'b0;
  logic                   rst_ni = 1'b0;
  logic [NCH*10-1:0]      smp_i = '0;
  logic [NCH-1:0]         smp_vld_i = '0;
  logic [NCH*NF*32-1:0]   cfg_i = '0;
  logic [NF-1:0]          match_o;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #4 clk_i = ~clk_i;

  adc_win_filter_bank i_adc_win_filter_bank (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .smp_i     (smp_i),
    .smp_vld_i (smp_vld_i),
    .cfg_i     (cfg_i),
    .match_o   (match_o)
  );

  function automatic logic [31:0] mkw(bit en, bit outs, int lo, int hi);
    logic [31:0] w = '0;
    w[31]    = en;
    w[27:18] = hi[9:0];
    w[12]    = outs;
    w[11:2]  = lo[9:0];
    return w;
  endfunction

  // independent model: outside = not inside; inside = neither below nor above
  function automatic logic [NF-1:0] model(logic [9:0] s0, logic [9:0] s1);
    logic [NF-1:0] r;
    for (int f = 0; f < NF; f++) begin
      r[f] = 1'b1;
      for (int c = 0; c < NCH; c++) begin
        logic [31:0] w;
        logic [9:0]  s;
        logic        ins;
        w   = cfg_i[(c*NF+f)*32 +: 32];
        s   = (c == 0) ? s0 : s1;
        ins = !(s < w[11:2]) && !(s > w[27:18]);
        if (!(w[31] && (w[12] ? !ins : ins))) r[f] = 1'b0;
      end
    end
    return r;
  endfunction

  task automatic check(string req, logic [NF-1:0] exp);
    total++;
    if (match_o !== exp) begin
      bad++;
      $display("FAIL %s: match_o=%b expected=%b", req, match_o, exp);
    end
  endtask

  task automatic strobe(logic [1:0] vld, logic [9:0] s0, logic [9:0] s1);
    @(negedge clk_i);
    smp_i     = {s1, s0};
    smp_vld_i = vld;
    @(negedge clk_i);
    smp_vld_i = '0;
  endtask

  task automatic load_cfg();
    for (int c = 0; c < NCH; c++) begin
      cfg_i[(c*NF+0)*32 +: 32] = mkw(1, 0, 100, 200);
      cfg_i[(c*NF+1)*32 +: 32] = mkw(1, 1, 100, 200);
      cfg_i[(c*NF+2)*32 +: 32] = mkw(1, 0, 0, 1023);
      cfg_i[(c*NF+3)*32 +: 32] = mkw(0, 0, 0, 1023);
      cfg_i[(c*NF+4)*32 +: 32] = mkw(1, 0, 512, 512);
      cfg_i[(c*NF+5)*32 +: 32] = mkw(1, 1, 300, 200);
      cfg_i[(c*NF+6)*32 +: 32] = mkw(1, 0, 300, 200);
      cfg_i[(c*NF+7)*32 +: 32] = mkw(c == 0, 0, 0, 1023);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    check("R1 reset value", '0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R1 after release", '0);

    // R5: all words reset to zero -> nothing enabled
    strobe(2'b11, 10'd0, 10'd0);
    check("R5 all disabled", '0);

    @(negedge clk_i);
    load_cfg();
    // R2: reserved bits set must not change anything
    for (int k = 0; k < NCH*NF; k++) begin
      cfg_i[k*32 +: 2]  = 2'b11;
      cfg_i[k*32+13 +: 5] = 5'h1f;
      cfg_i[k*32+28 +: 3] = 3'h7;
    end

    for (int v = 0; v < NV; v++) begin
      strobe(2'b11, VEC[v][19:10], VEC[v][9:0]);
      check("R6 table vector", model(VEC[v][19:10], VEC[v][9:0]));
    end

    // hand-worked vectors
    strobe(2'b11, 10'd150, 10'd150);
    check("R3 inside window, R8 swapped bounds, R2 fields", 8'h25);
    strobe(2'b11, 10'd99, 10'd201);
    check("R4 outside window", 8'h26);
    strobe(2'b11, 10'd100, 10'd200);
    check("R3 inclusive bounds", 8'h25);
    strobe(2'b11, 10'd512, 10'd512);
    check("R3 single point window", 8'h36);

    // R7 / R9: channel 0 strobe alone holds output
    strobe(2'b01, 10'd150, 10'd0);
    check("R7 hold on ch0 strobe", 8'h36);
    @(negedge clk_i);
    smp_i = {10'd99, 10'd0};
    @(negedge clk_i);
    check("R7 hold without strobe", 8'h36);
    // R9: ch1 strobe alone uses stored ch0 value 150
    strobe(2'b10, 10'd0, 10'd150);
    check("R9 stored ch0 sample used", 8'h25);

    // R7: output does not move before the edge that samples the strobe
    @(negedge clk_i);
    smp_i = {10'd99, 10'd99};
    smp_vld_i = 2'b11;
    #1;
    check("R7 no change before edge", 8'h25);
    @(negedge clk_i);
    smp_vld_i = '0;
    check("R7 update one cycle later", 8'h26);

    // R6: slot 7 enabled only on channel 0
    strobe(2'b11, 10'd5, 10'd5);
    check("R6 one-sided enable", model(10'd5, 10'd5));
    if (match_o[7] !== 1'b0) begin
      bad++;
      $display("FAIL R6: bit7=%b expected=0", match_o[7]);
    end
    total++;

    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!finished) begin
      finished = 1;
      total++;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule